// File: doc/BRIEF.md
# Cascadable Command and Fault Serial Shifter

This block is the serial front end of a six-channel low-side gate predriver. A host selects the device by pulling an active-low select line low. It then clocks in one byte per device on a serial data line, where each bit switches one gate channel on or off. At the same time it clocks out an eight-bit fault picture of the device. That picture is frozen when select falls: battery over-voltage, battery under-voltage and one load-fault flag per channel.

Bits entering the device come back out on the serial output once its own eight fault bits have gone. Several devices can therefore be chained output-to-input, and the host sends eight bits per device. When select rises, the last six bits shifted in become the gate command. The serial output is released and the fault store goes back to following the live fault inputs.

The serial pins are asynchronous to the block clock. Select, serial clock and serial data pass through synchronisers, and their edges are recovered in the clock domain. The serial clock must run slower than a quarter of the block clock. The analog comparators and gate stages are outside the block, and faults arrive as logic levels.

Top module: `cmdFaultShifter`

## Requirements
- R1: While reset is asserted, gateCmd is all zeros, sdoOe is 0 and faultFlag is 0.
- R2: sdoOe goes high a few block clocks after csN falls, stays high for the whole frame, and goes low a few block clocks after csN rises.
- R3: On the csN falling edge the fault inputs are captured and then presented on sdo MSB first. Bit 7 (the first bit out) is over-voltage, bit 6 is under-voltage, and bits 5..0 are the load faults of channels 5..0. A 1 means a fault. The first bit is valid before the first rising serial clock edge.
- R4: A fault that appears while csN is low does not show in that frame's sdo bits, and faultFlag does not change while sdoOe stays high.
- R5: sdi is sampled at the rising edge of sclk, and its value while sclk is high has no effect. sdo changes only after a falling sclk edge or the csN falling edge.
- R6: After the eight fault bits, sdo repeats the sdi bits in the order they were sent, delayed by eight bit times.
- R7: On the csN rising edge, gateCmd takes the last six bits shifted in: the very last bit drives channel 0 and the sixth-from-last drives channel 5. A 1 turns a channel on and a 0 turns it off. gateCmd does not change at any other time.
- R8: While csN is high, faultFlag is the OR of the live fault inputs, after synchroniser latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select from host |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (fault bits, then pass-through) |
| sdoOe | output | 1 | Drive enable for the sdo pad; pad floats when 0 |
| ovFault | input | 1 | Battery over-voltage fault level |
| uvFault | input | 1 | Battery under-voltage fault level |
| loadFault | input | 6 | Per-channel short/open load fault levels |
| gateCmd | output | 6 | Committed channel on/off command |
| faultFlag | output | 1 | Any-fault flag, live while idle and frozen during a frame |

## Verification
The assertions take for granted several timing conditions on the host signals. The sclk and csN edges must be separated by more than the synchroniser latency. sdi must be settled before the rising sclk edge has passed through the synchroniser. An sclk edge must never share a block clock with a csN edge. The stimulus holds every serial clock phase for eight block clocks. It waits the same interval between a csN edge and the nearest sclk edge. It changes fault inputs only well away from a select edge, so every strobe the checker reasons about is clean and isolated.

// File: rtl/cfsPkg.sv
package cfsPkg;
  // Single-cycle event strobes recovered from the serial pins.
  typedef struct packed {
    logic csFall;
    logic csRise;
    logic sclkRise;
    logic sclkFall;
    logic sdiBit;
  } cfsStrobes_t;
endpackage

// File: rtl/cfsSync.sv
module cfsSync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= d;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= RST_VAL;
        else       stage[g] <= stage[g-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cfsCtrl.sv
module cfsCtrl
  import cfsPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  output cfsStrobes_t strb
);
  logic [2:0] syncBus;
  logic csS, sclkS, sdiS;
  logic csPrev, sclkPrev;

  cfsSync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN), .d({csN, sclk, sdi}), .q(syncBus)
  );

  assign {csS, sclkS, sdiS} = syncBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  always_comb begin
    strb.csFall   = csPrev & ~csS;
    strb.csRise   = ~csPrev & csS;
    strb.sclkRise = ~sclkPrev & sclkS & ~csS;
    strb.sclkFall = sclkPrev & ~sclkS & ~csS;
    strb.sdiBit   = sdiS;
  end
endmodule

// File: rtl/cfsDatapath.sv
module cfsDatapath
  import cfsPkg::*;
#(
  parameter int CHANNELS = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfsStrobes_t         strb,
  input  logic                ovFault,
  input  logic                uvFault,
  input  logic [CHANNELS-1:0] loadFault,
  output logic                sdo,
  output logic                sdoOe,
  output logic [CHANNELS-1:0] gateCmd,
  output logic                faultFlag
);
  localparam int FRAME_BITS = CHANNELS + 2;

  logic [FRAME_BITS-1:0] faultSync;
  logic [FRAME_BITS-1:0] faultReg;
  logic [FRAME_BITS-1:0] shReg;
  logic [CHANNELS-1:0]   gateReg;
  logic                  sdoReg;
  logic                  csActive;

  cfsSync #(.W(FRAME_BITS), .STAGES(SYNC_STAGES), .RST_VAL('0)) uFaultSync (
    .clk(clk), .rstN(rstN), .d({ovFault, uvFault, loadFault}), .q(faultSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      faultReg <= '0;
      gateReg  <= '0;
      sdoReg   <= 1'b0;
      csActive <= 1'b0;
    end else if (strb.csFall) begin
      // Snapshot faults and present the first (MSB) bit at once.
      csActive <= 1'b1;
      shReg    <= faultSync;
      faultReg <= faultSync;
      sdoReg   <= faultSync[FRAME_BITS-1];
    end else if (strb.csRise) begin
      // Commit command, release pad, clear and re-arm the fault store.
      csActive <= 1'b0;
      gateReg  <= shReg[CHANNELS-1:0];
      faultReg <= '0;
    end else begin
      if (!csActive) faultReg <= faultSync;
      if (csActive && strb.sclkRise) shReg <= {shReg[FRAME_BITS-2:0], strb.sdiBit};
      if (csActive && strb.sclkFall) sdoReg <= shReg[FRAME_BITS-1];
    end
  end

  assign sdo       = sdoReg;
  assign sdoOe     = csActive;
  assign gateCmd   = gateReg;
  assign faultFlag = |faultReg;
endmodule

// File: rtl/cmdFaultShifter.sv
module cmdFaultShifter
  import cfsPkg::*;
#(
  parameter int CHANNELS = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic                sdi,
  output logic                sdo,
  output logic                sdoOe,
  input  logic                ovFault,
  input  logic                uvFault,
  input  logic [CHANNELS-1:0] loadFault,
  output logic [CHANNELS-1:0] gateCmd,
  output logic                faultFlag
);
  cfsStrobes_t strb;

  cfsCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .strb(strb)
  );

  cfsDatapath #(.CHANNELS(CHANNELS), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ovFault(ovFault), .uvFault(uvFault), .loadFault(loadFault),
    .sdo(sdo), .sdoOe(sdoOe), .gateCmd(gateCmd), .faultFlag(faultFlag)
  );
endmodule

// File: rtl/cfsChecker.sv
module cfsChecker
  import cfsPkg::*;
#(
  parameter int CHANNELS = 6
) (
  input logic                clk,
  input logic                rstN,
  input cfsStrobes_t         strb,
  input logic                sdo,
  input logic                sdoOe,
  input logic [CHANNELS-1:0] gateCmd,
  input logic                faultFlag
);
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_values: assert (gateCmd == '0 && !sdoOe && !faultFlag)
        else $error("R1 outputs not at reset values");
    end
  end

  a_r2_oe_on: assert property (@(posedge clk) disable iff (!rstN)
    strb.csFall |=> sdoOe);

  a_r2_oe_off: assert property (@(posedge clk) disable iff (!rstN)
    strb.csRise |=> !sdoOe);

  a_r4_flag_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && $past(sdoOe)) |-> $stable(faultFlag));

  a_r5_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdo) |-> $past(strb.sclkFall || strb.csFall));

  a_r7_cmd_only_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gateCmd) |-> $past(strb.csRise));
endmodule

bind cmdFaultShifter cfsChecker #(.CHANNELS(CHANNELS)) uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .sdo(sdo), .sdoOe(sdoOe),
  .gateCmd(gateCmd), .faultFlag(faultFlag)
);

// File: tb/sim_cmdFaultShifter.sv
module sim_cmdFaultShifter;
  localparam int CH = 6;
  localparam int PH = 8;

  typedef struct {
    logic  val;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic ovFault = 1'b0;
  logic uvFault = 1'b0;
  logic [CH-1:0] loadFault = '0;
  logic sdo, sdoOe, faultFlag;
  logic [CH-1:0] gateCmd;

  int nChecks = 0;
  int nFail = 0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  cmdFaultShifter #(.CHANNELS(CH)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .ovFault(ovFault), .uvFault(uvFault),
    .loadFault(loadFault), .gateCmd(gateCmd), .faultFlag(faultFlag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare sdo against the scoreboard at each host rising edge.
  always @(posedge sclk) begin
    if (!csN) begin
      check(sdoOe === 1'b1, "R2", {31'd0, sdoOe}, 1);
      if (expQ.size() == 0) begin
        check(1'b0, "R6 queue underflow", 0, 1);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(sdo === e.val, e.req, {31'd0, sdo}, {31'd0, e.val});
      end
    end
  end

  // Driver: send nBits of data MSB first, optionally changing faults mid-frame.
  task automatic frame(input logic [15:0] data, input int nBits,
                       input logic [7:0] midFault, input bit doMid);
    logic [7:0] snap;
    logic [CH-1:0] gateBefore;
    snap = {ovFault, uvFault, loadFault};
    gateBefore = gateCmd;
    csN = 1'b0;
    waitCyc(PH);
    for (int k = 0; k < nBits; k++) begin
      expItem_t e;
      logic b;
      b = data[nBits-1-k];
      if (k < 8) begin e.val = snap[7-k]; e.req = "R3"; end
      else begin e.val = data[nBits-1-(k-8)]; e.req = "R6"; end
      expQ.push_back(e);
      sdi = b;
      waitCyc(PH);
      sclk = 1'b1;
      waitCyc(2);
      sdi = ~b;  // R5: value while sclk is high must be ignored
      waitCyc(PH - 2);
      sclk = 1'b0;
      if (doMid && k == 3) {ovFault, uvFault, loadFault} = midFault;
    end
    waitCyc(PH);
    // R4: flag frozen at the snapshot; R7: command untouched mid-frame
    check(faultFlag === (|snap), "R4", {31'd0, faultFlag}, {31'd0, |snap});
    check(gateCmd === gateBefore, "R7", {26'd0, gateCmd}, {26'd0, gateBefore});
    csN = 1'b1;
    waitCyc(PH);
    check(sdoOe === 1'b0, "R2", {31'd0, sdoOe}, 0);
    check(expQ.size() == 0, "R6", expQ.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    waitCyc(4);
    // R1
    check(gateCmd === '0, "R1", {26'd0, gateCmd}, 0);
    check(sdoOe === 1'b0, "R1", {31'd0, sdoOe}, 0);
    check(faultFlag === 1'b0, "R1", {31'd0, faultFlag}, 0);
    rstN = 1'b1;
    waitCyc(6);

    // R8: live flag while idle
    loadFault = 6'h04;
    waitCyc(6);
    check(faultFlag === 1'b1, "R8", {31'd0, faultFlag}, 1);
    loadFault = '0;
    waitCyc(6);
    check(faultFlag === 1'b0, "R8", {31'd0, faultFlag}, 0);

    // R3/R7: over-voltage + channel 0 fault, command 0x2A
    ovFault = 1'b1; loadFault = 6'h01;
    waitCyc(6);
    frame(16'h00EA, 8, 8'h00, 1'b0);
    check(gateCmd === 6'h2A, "R7", {26'd0, gateCmd}, 6'h2A);
    ovFault = 1'b0; loadFault = '0;
    waitCyc(6);

    // R4: fault appearing mid-frame is not reported
    frame(16'h0015, 8, 8'h10, 1'b1);
    check(gateCmd === 6'h15, "R7", {26'd0, gateCmd}, 6'h15);
    waitCyc(6);
    check(faultFlag === 1'b1, "R8", {31'd0, faultFlag}, 1);
    loadFault = '0;
    waitCyc(6);

    // R6: two-byte chain frame, under-voltage snapshot
    uvFault = 1'b1;
    waitCyc(6);
    frame(16'hC33C, 16, 8'h00, 1'b0);
    check(gateCmd === 6'h3C, "R7", {26'd0, gateCmd}, 6'h3C);
    uvFault = 1'b0;
    waitCyc(6);

    // R7: all on, then all off; load faults on all channels
    loadFault = 6'h3F;
    waitCyc(6);
    frame(16'h003F, 8, 8'h00, 1'b0);
    check(gateCmd === 6'h3F, "R7", {26'd0, gateCmd}, 6'h3F);
    loadFault = '0;
    waitCyc(6);
    frame(16'h00C0, 8, 8'h00, 1'b0);
    check(gateCmd === 6'h00, "R7", {26'd0, gateCmd}, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule